// File: doc/BRIEF.md
# Dual-Port RAM with Address-Collision Arbitration

This block is a synchronous true dual-port memory with two independent ports, called left and right. Each port has its own enable, write strobe, read strobe, address, write data and read data. Either port can read or write any word at any time, and both ports can address the same word in the same cycle.

A collision unit compares the two addresses on every clock edge. When both ports are enabled on the same word, the port that arrived earlier keeps the word. The other port receives a BUSY flag, and its writes are discarded for as long as it loses.

A mode strap selects the role of the block. With the strap high, the block is the master: it arbitrates internally and drives the BUSY flags. With the strap low, the block is a slave: its own arbitration has no effect, and an externally supplied BUSY per port gates the writes. Several slaves can then follow one master so that the data word can be made wider.

Top module: `dpram_collide`

## Requirements
- R1: A write (enable and write strobe high, port not blocked) at a clock edge stores the write data at the address. From the next edge onward, reads on either port see that value. If both ports write the same word at the same edge without being blocked, the left value is stored.
- R2: A read (enable and read strobe high) at an edge loads the read-data register at that edge with the word as it was before any write at that same edge. Without a read, the read-data register holds its value.
- R3: In master mode, a port's BUSY output is high after an edge only if both enables were high and the addresses were equal at that edge.
- R4: On an address match, a port that was enabled on that same address at the previous edge, while the other port was not, wins the word. The other port's BUSY is high after the edge.
- R5: If both ports reach the matching address at the same edge, the left port wins, and the right BUSY goes high.
- R6: The winner keeps the word for as long as the match persists and its own enable and address are unchanged. The loser's BUSY falls at the first edge where the match is gone.
- R7: In master mode, a write from the losing port at an edge that sets its BUSY is discarded and not queued. The word keeps its previous value.
- R8: In slave mode both BUSY outputs stay low, and internal arbitration has no effect on writes. A port's write at an edge is discarded exactly when that port's BUSY input is high at that edge.
- R9: After reset both BUSY outputs are low and both read-data registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | Mode strap: 1 = master (arbitrates), 0 = slave |
| ce_l | input | 1 | Left port enable |
| we_l | input | 1 | Left port write strobe |
| oe_l | input | 1 | Left port read strobe |
| addr_l | input | ADDR_W | Left port address |
| wdata_l | input | DATA_W | Left port write data |
| rdata_l | output | DATA_W | Left port registered read data |
| busy_in_l | input | 1 | Left BUSY from a master (slave mode) |
| busy_out_l | output | 1 | Left BUSY driven in master mode |
| ce_r | input | 1 | Right port enable |
| we_r | input | 1 | Right port write strobe |
| oe_r | input | 1 | Right port read strobe |
| addr_r | input | ADDR_W | Right port address |
| wdata_r | input | DATA_W | Right port write data |
| rdata_r | output | DATA_W | Right port registered read data |
| busy_in_r | input | 1 | Right BUSY from a master (slave mode) |
| busy_out_r | output | 1 | Right BUSY driven in master mode |

## Verification
BUSY and read data are both due one edge after the stimulus that causes them. The write-gating decision is made at that same edge.

The bench applies each vector on a falling edge and lets one rising edge pass. At the next falling edge it compares BUSY and read data against values taken from the vector table and from a reference array. The reference array is updated with the discard rule of that same edge.

A discarded write is confirmed one edge later, through a read of the word from either port.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Ownership decision for one edge: a sitting owner keeps the word,
    // otherwise the earlier arrival wins and a tie goes to the left port.
    function automatic owner_e arbitrate(input owner_e cur, input logic match,
                                         input logic l_early, input logic r_early);
        owner_e res;
        if (!match)
            res = OWN_NONE;
        else if (cur == OWN_LEFT && l_early)
            res = OWN_LEFT;
        else if (cur == OWN_RIGHT && r_early)
            res = OWN_RIGHT;
        else if (r_early && !l_early)
            res = OWN_RIGHT;
        else
            res = OWN_LEFT;
        return res;
    endfunction

endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_l,
    input  logic              ce_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    output logic              lose_l,
    output logic              lose_r,
    output logic              busy_l,
    output logic              busy_r
);

    typedef struct packed {
        owner_e              owner;
        logic                ce_l;
        logic                ce_r;
        logic [ADDR_W-1:0]   addr_l;
        logic [ADDR_W-1:0]   addr_r;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    match, l_early, r_early;

    always_comb begin
        st_d    = st_q;
        match   = ce_l && ce_r && (addr_l == addr_r);
        l_early = st_q.ce_l && (st_q.addr_l == addr_l);
        r_early = st_q.ce_r && (st_q.addr_r == addr_r);
        st_d.owner  = arbitrate(st_q.owner, match, l_early, r_early);
        st_d.ce_l   = ce_l;
        st_d.ce_r   = ce_r;
        st_d.addr_l = addr_l;
        st_d.addr_r = addr_r;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NONE, ce_l: 1'b0, ce_r: 1'b0,
                      addr_l: '0, addr_r: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lose_l = (st_d.owner == OWN_RIGHT);
    assign lose_r = (st_d.owner == OWN_LEFT);
    assign busy_l = (st_q.owner == OWN_RIGHT);
    assign busy_r = (st_q.owner == OWN_LEFT);

    // R3: no flag without a match at the edge that sets it
    a_r3_no_busy_without_match: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> (!busy_l && !busy_r));

    // R4: the earlier arrival wins
    a_r4_left_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (match && l_early && !r_early) |=> busy_r);

    a_r4_right_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (match && r_early && !l_early) |=> busy_l);

    // R5: a simultaneous arrival goes to the left port
    a_r5_tie_to_left: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !l_early && !r_early) |=> busy_r);

    // R6: the owner keeps the word while it stays put
    a_r6_owner_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_r && match && l_early) |=> busy_r);

endmodule

// File: rtl/dpram_core.sv
module dpram_core #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen_l,
    input  logic              wen_r,
    input  logic              ren_l,
    input  logic              ren_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wdata_l,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] rdata_l,
    output logic [DATA_W-1:0] rdata_r
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] rd_l;
        logic [DATA_W-1:0] rd_r;
    } rd_st_t;

    logic [DATA_W-1:0] mem [DEPTH];
    rd_st_t rd_d, rd_q;

    // Right written first so the left value stands on a shared word.
    always_ff @(posedge clk) begin
        if (wen_r) mem[addr_r] <= wdata_r;
        if (wen_l) mem[addr_l] <= wdata_l;
    end

    always_comb begin
        rd_d = rd_q;
        if (ren_l) rd_d.rd_l = mem[addr_l];
        if (ren_r) rd_d.rd_r = mem[addr_r];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata_l = rd_q.rd_l;
    assign rdata_r = rd_q.rd_r;

    // R2: a read returns the word as it was before the edge's writes
    a_r2_read_old_left: assert property (@(posedge clk) disable iff (!rst_n)
        ren_l |=> (rdata_l == $past(mem[addr_l])));

    a_r2_read_old_right: assert property (@(posedge clk) disable iff (!rst_n)
        ren_r |=> (rdata_r == $past(mem[addr_r])));

    // R1: with no write enabled, the word stays unchanged
    a_r1_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wen_l && !wen_r) |=> (mem[$past(addr_l)] == $past(mem[addr_l])));

endmodule

// File: rtl/dpram_collide.sv
module dpram_collide #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic              ce_l,
    input  logic              we_l,
    input  logic              oe_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] wdata_l,
    output logic [DATA_W-1:0] rdata_l,
    input  logic              busy_in_l,
    output logic              busy_out_l,
    input  logic              ce_r,
    input  logic              we_r,
    input  logic              oe_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] rdata_r,
    input  logic              busy_in_r,
    output logic              busy_out_r
);

    logic lose_l, lose_r, busy_l, busy_r;
    logic block_l, block_r, wen_l, wen_r, ren_l, ren_r;

    dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_l   (ce_l),
        .ce_r   (ce_r),
        .addr_l (addr_l),
        .addr_r (addr_r),
        .lose_l (lose_l),
        .lose_r (lose_r),
        .busy_l (busy_l),
        .busy_r (busy_r)
    );

    always_comb begin
        block_l    = master ? lose_l : busy_in_l;
        block_r    = master ? lose_r : busy_in_r;
        wen_l      = ce_l && we_l && !block_l;
        wen_r      = ce_r && we_r && !block_r;
        ren_l      = ce_l && oe_l;
        ren_r      = ce_r && oe_r;
        busy_out_l = master && busy_l;
        busy_out_r = master && busy_r;
    end

    dpram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wen_l   (wen_l),
        .wen_r   (wen_r),
        .ren_l   (ren_l),
        .ren_r   (ren_r),
        .addr_l  (addr_l),
        .addr_r  (addr_r),
        .wdata_l (wdata_l),
        .wdata_r (wdata_r),
        .rdata_l (rdata_l),
        .rdata_r (rdata_r)
    );

    // R7: a flagged master-mode loser leaves no write behind
    a_r7_loser_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (master && lose_r) |-> !wen_r);

    // R8: a slave never drives its own flags after an edge in slave mode
    a_r8_slave_flags_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && $stable(master)) |=> (master || (!busy_out_l && !busy_out_r)));

endmodule

// File: tb/test_dpram_collide.sv
module test_dpram_collide;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int NV = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master = 1'b1;
    logic ce_l = 0, we_l = 0, oe_l = 0, busy_in_l = 0;
    logic ce_r = 0, we_r = 0, oe_r = 0, busy_in_r = 0;
    logic [AW-1:0] addr_l = '0, addr_r = '0;
    logic [DW-1:0] wdata_l = '0, wdata_r = '0;
    logic [DW-1:0] rdata_l, rdata_r;
    logic busy_out_l, busy_out_r;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] ref_mem [1<<AW];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_collide #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_collide (
        .clk(clk), .rst_n(rst_n), .master(master),
        .ce_l(ce_l), .we_l(we_l), .oe_l(oe_l), .addr_l(addr_l), .wdata_l(wdata_l),
        .rdata_l(rdata_l), .busy_in_l(busy_in_l), .busy_out_l(busy_out_l),
        .ce_r(ce_r), .we_r(we_r), .oe_r(oe_r), .addr_r(addr_r), .wdata_r(wdata_r),
        .rdata_r(rdata_r), .busy_in_r(busy_in_r), .busy_out_r(busy_out_r)
    );

    // {ce_l, we_l, a_l, d_l, ce_r, we_r, a_r, d_r, exp_busy_l, exp_busy_r}
    localparam logic [33:0] VEC [NV] = '{
        {1'b1,1'b1,6'd5,8'h11, 1'b0,1'b0,6'd0,8'h00, 2'b00},
        {1'b1,1'b0,6'd5,8'h00, 1'b1,1'b1,6'd5,8'h22, 2'b01},
        {1'b1,1'b0,6'd5,8'h00, 1'b1,1'b1,6'd5,8'h33, 2'b01},
        {1'b1,1'b1,6'd6,8'h44, 1'b1,1'b1,6'd5,8'h55, 2'b00},
        {1'b1,1'b1,6'd7,8'h66, 1'b1,1'b1,6'd7,8'h77, 2'b01},
        {1'b0,1'b0,6'd7,8'h00, 1'b1,1'b1,6'd7,8'h88, 2'b00},
        {1'b1,1'b1,6'd7,8'h99, 1'b1,1'b0,6'd7,8'h00, 2'b10},
        {1'b1,1'b1,6'd7,8'h9A, 1'b1,1'b0,6'd7,8'h00, 2'b10},
        {1'b1,1'b1,6'd7,8'hAB, 1'b0,1'b0,6'd0,8'h00, 2'b00},
        {1'b0,1'b0,6'd0,8'h00, 1'b0,1'b0,6'd0,8'h00, 2'b00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ce_l = 0; we_l = 0; oe_l = 0; ce_r = 0; we_r = 0; oe_r = 0;
        busy_in_l = 0; busy_in_r = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] exp_l, exp_r;
        @(negedge clk);
        tick();
        rst_n = 1'b1;
        // R9: reset state
        check("R9 busy_out_l", busy_out_l, 0);
        check("R9 busy_out_r", busy_out_r, 0);
        check("R9 rdata_l", rdata_l, 0);
        check("R9 rdata_r", rdata_r, 0);

        // clear the memory through the left port
        for (int a = 0; a < (1<<AW); a++) begin
            ce_l = 1; we_l = 1; addr_l = AW'(a); wdata_l = '0;
            ref_mem[a] = '0;
            tick();
        end
        idle();
        tick();

        // master-mode vector walk
        exp_l = rdata_l;
        exp_r = rdata_r;
        for (int i = 0; i < NV; i++) begin
            logic [33:0] v;
            v = VEC[i];
            ce_l = v[33]; we_l = v[32]; oe_l = v[33]; addr_l = v[31:26]; wdata_l = v[25:18];
            ce_r = v[17]; we_r = v[16]; oe_r = v[17]; addr_r = v[15:10]; wdata_r = v[9:2];
            if (v[33]) exp_l = ref_mem[v[31:26]];
            if (v[17]) exp_r = ref_mem[v[15:10]];
            // R7: only an unflagged write reaches the reference; left lands last (R1)
            if (v[17] && v[16] && !v[0]) ref_mem[v[15:10]] = v[9:2];
            if (v[33] && v[32] && !v[1]) ref_mem[v[31:26]] = v[25:18];
            tick();
            check($sformatf("R3/R4/R5/R6 busy_l step %0d", i), busy_out_l, v[1]);
            check($sformatf("R3/R4/R5/R6 busy_r step %0d", i), busy_out_r, v[0]);
            check($sformatf("R2 rdata_l step %0d", i), rdata_l, exp_l);
            check($sformatf("R2 rdata_r step %0d", i), rdata_r, exp_r);
        end

        // R1/R7: read back collided words from the right port
        idle();
        ce_r = 1; oe_r = 1; addr_r = 6'd5; tick();
        check("R1 word 5 holds unflagged write", rdata_r, 8'h55);
        addr_r = 6'd6; tick();
        check("R1 word 6", rdata_r, 8'h44);
        addr_r = 6'd7; tick();
        check("R7 word 7 keeps only unflagged writes", rdata_r, 8'hAB);
        idle();
        tick();

        // slave mode
        master = 1'b0;
        tick();
        ce_l = 1; we_l = 1; addr_l = 6'd9; wdata_l = 8'hC1;
        ce_r = 1; we_r = 1; addr_r = 6'd9; wdata_r = 8'hC2;
        tick();
        check("R8 slave busy_out_l low on match", busy_out_l, 0);
        check("R8 slave busy_out_r low on match", busy_out_r, 0);
        we_l = 0; we_r = 0; oe_l = 1; oe_r = 1;
        tick();
        check("R1 shared write keeps left value (left)", rdata_l, 8'hC1);
        check("R1 shared write keeps left value (right)", rdata_r, 8'hC1);

        idle();
        ce_r = 1; we_r = 1; addr_r = 6'd10; wdata_r = 8'hD1; busy_in_r = 1;
        ce_l = 1; we_l = 1; addr_l = 6'd11; wdata_l = 8'hE1;
        tick();
        idle();
        ce_l = 1; we_l = 1; addr_l = 6'd11; wdata_l = 8'hE2; busy_in_l = 1;
        ce_r = 1; oe_r = 1; addr_r = 6'd10;
        tick();
        check("R8 flagged right write dropped", rdata_r, 8'h00);
        idle();
        ce_l = 1; oe_l = 1; addr_l = 6'd11;
        tick();
        check("R8 left write kept, flagged one dropped", rdata_l, 8'hE1);

        // slave: a late arrival is not blocked by internal arbitration
        ce_l = 1; oe_l = 1; addr_l = 6'd12;
        tick();
        ce_r = 1; we_r = 1; addr_r = 6'd12; wdata_r = 8'hF5;
        tick();
        check("R8 slave flag stays low", busy_out_r, 0);
        idle();
        ce_r = 1; oe_r = 1; addr_r = 6'd12;
        tick();
        check("R8 late write lands in slave mode", rdata_r, 8'hF5);

        // R2: no read leaves the register unchanged
        idle();
        ce_r = 1; we_r = 1; addr_r = 6'd12; wdata_r = 8'h01;
        tick();
        check("R2 rdata_r holds without read", rdata_r, 8'hF5);
        idle();
        tick();
        finish_run();
    end

endmodule